// File: doc/BRIEF.md
# Priority-Weighted DMA Channel Arbiter

A DMA engine with several channels draws on one shared pool of bus bandwidth, and this block decides which channel owns the bus next. Each channel presents a request line, a one-bit priority class and a four-bit weight, all sampled from static configuration inputs. A requesting channel in the high class always wins over any channel in the low class. Inside a class, grants are shared in proportion to the weights through per-channel credit counters and a rotating search pointer.

After a grant, the chosen channel owns the bus until it pulses `done`. The block then returns to idle and arbitrates again on the following cycle. The number of channels is a parameter, with a default of six.

Top module: `dma_bw_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `gnt` is all zeros and `gnt_valid` is low.
- R2: When the block is idle and at least one `req` bit is high at a rising edge, that edge loads a one-hot `gnt` naming a requesting channel. In the same cycle `gnt_valid` is high for exactly one cycle.
- R3: Bit i of `prio` set to 1 puts channel i in the high class. While any high-class channel requests, no low-class channel is granted.
- R4: `gnt` holds its value until `done` is sampled high, even if `req` falls. A `done` pulse while no grant is held has no effect.
- R5: The edge that samples `done` high during a grant clears `gnt`. The next grant can appear at the edge after that.
- R6: Each channel has a credit counter. A grant uses one credit. Only requesters with credit left are eligible. If all channels in one class request continuously, a channel with effective weight w receives w grants in each reload window.
- R7: The weight of channel i is `weight[4*i+3:4*i]`, read as an unsigned value 1 to 15. A field of 0 counts as 1.
- R8: Each class keeps its own search pointer. The search starts at the channel after the one last granted in that class and wraps from channel N-1 to 0. Channels of equal weight therefore take turns.
- R9: When a class wins arbitration and none of its requesters has credit left, every channel of that class is reloaded with its effective weight before the pick. Reset clears all credits to zero.
- R10: With all `req` bits low, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_CH | Request line per channel |
| prio | input | N_CH | Class per channel, 1 = high |
| weight | input | 4*N_CH | Four-bit weight per channel, channel i at bits 4i+3..4i |
| done | input | 1 | Current owner yields the bus |
| gnt | output | N_CH | One-hot grant, held until done |
| gnt_valid | output | 1 | One-cycle strobe marking a new grant |

## Verification
The hardest case to reach from the ports is a credit reload that happens while other channels of the same class still hold leftover credit from an earlier window. The reload then overwrites unequal counters and moves the rotation onto a new phase. The stimulus reaches this state by running uneven weights across several full windows, and by letting high-class traffic interrupt a low-class window partway through. A reference model in the bench tracks credits and pointers for both classes and predicts every grant. Hand-computed counts check the weight ratios and the zero-weight case independently of that model.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NUM_LVL = 2;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;
endpackage

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int N_CH = 6,
    parameter int CW   = 3
) (
    input  logic [N_CH-1:0] elig,
    input  logic [CW-1:0]   ptr,
    output logic            found,
    output logic [CW-1:0]   idx
);
    function automatic logic [CW-1:0] pos_of(logic [CW-1:0] base, int k);
        int s;
        s = int'(base) + k;
        if (s >= N_CH) begin
            s = s - N_CH;
        end
        return CW'(s);
    endfunction

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N_CH; k++) begin
            if (!found && elig[pos_of(ptr, k)]) begin
                found = 1'b1;
                idx   = pos_of(ptr, k);
            end
        end
    end
endmodule

// File: rtl/dma_arb_credit_bank.sv
module dma_arb_credit_bank #(
    parameter int N_CH  = 6,
    parameter int WGT_W = 4,
    parameter int CW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH*WGT_W-1:0] wgt_eff,
    input  logic [N_CH-1:0]       prio,
    input  logic                  reload,
    input  logic                  reload_lvl,
    input  logic                  take,
    input  logic [CW-1:0]         take_idx,
    output logic [N_CH-1:0]       has_credit
);
    typedef struct packed {
        logic [N_CH-1:0][WGT_W-1:0] cr;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N_CH; i++) begin
            if (reload && (prio[i] == reload_lvl)) begin
                bank_d.cr[i] = wgt_eff[i*WGT_W +: WGT_W];
            end
            if (take && (take_idx == CW'(i))) begin
                bank_d.cr[i] = bank_d.cr[i] - WGT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_flag
        assign has_credit[i] = (bank_q.cr[i] != '0);
    end
endmodule

// File: rtl/dma_bw_arbiter.sv
module dma_bw_arbiter
    import dma_arb_pkg::*;
#(
    parameter int N_CH  = 6,
    parameter int WGT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH-1:0]       req,
    input  logic [N_CH-1:0]       prio,
    input  logic [N_CH*WGT_W-1:0] weight,
    input  logic                  done,
    output logic [N_CH-1:0]       gnt,
    output logic                  gnt_valid
);
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

    typedef struct packed {
        logic                          busy;
        logic [N_CH-1:0]               gnt;
        logic                          gv;
        logic [NUM_LVL-1:0][CW-1:0]    ptr;
    } state_t;

    state_t st_d, st_q;

    logic [N_CH*WGT_W-1:0]            wgt_eff;
    logic [N_CH-1:0]                  has_credit;
    logic [NUM_LVL-1:0][N_CH-1:0]     cand;
    logic [NUM_LVL-1:0][N_CH-1:0]     elig;
    logic [NUM_LVL-1:0][N_CH-1:0]     pick_set;
    logic [NUM_LVL-1:0]               reload_need;
    logic [NUM_LVL-1:0]               found;
    logic [NUM_LVL-1:0][CW-1:0]       idx;

    lvl_e                             sel;
    logic                             arb_go;
    logic                             do_reload;

    // zero weight promoted to one
    for (genvar i = 0; i < N_CH; i++) begin : g_wgt
        assign wgt_eff[i*WGT_W +: WGT_W] =
            (weight[i*WGT_W +: WGT_W] == '0) ? WGT_W'(1) : weight[i*WGT_W +: WGT_W];
    end

    // one candidate set and one rotating picker per class
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign cand[l]        = req & ((l == int'(LVL_HI)) ? prio : ~prio);
        assign elig[l]        = cand[l] & has_credit;
        assign reload_need[l] = (|cand[l]) & ~(|elig[l]);
        assign pick_set[l]    = reload_need[l] ? cand[l] : elig[l];

        dma_arb_rr_pick #(
            .N_CH (N_CH),
            .CW   (CW)
        ) u_pick (
            .elig  (pick_set[l]),
            .ptr   (st_q.ptr[l]),
            .found (found[l]),
            .idx   (idx[l])
        );
    end

    always_comb begin
        sel       = (|cand[LVL_HI]) ? LVL_HI : LVL_LO;
        arb_go    = !st_q.busy && found[sel];
        do_reload = arb_go && reload_need[sel];

        st_d    = st_q;
        st_d.gv = 1'b0;
        if (st_q.busy) begin
            if (done) begin
                st_d.busy = 1'b0;
                st_d.gnt  = '0;
            end
        end else if (arb_go) begin
            st_d.busy     = 1'b1;
            st_d.gv       = 1'b1;
            st_d.gnt      = N_CH'(1) << idx[sel];
            st_d.ptr[sel] = (idx[sel] == CW'(N_CH - 1)) ? '0 : idx[sel] + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dma_arb_credit_bank #(
        .N_CH  (N_CH),
        .WGT_W (WGT_W),
        .CW    (CW)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wgt_eff    (wgt_eff),
        .prio       (prio),
        .reload     (do_reload),
        .reload_lvl (sel),
        .take       (arb_go),
        .take_idx   (idx[sel]),
        .has_credit (has_credit)
    );

    assign gnt       = st_q.gnt;
    assign gnt_valid = st_q.gv;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
    parameter int N_CH = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] req,
    input logic [N_CH-1:0] prio,
    input logic            done,
    input logic [N_CH-1:0] gnt,
    input logic            gnt_valid
);
    logic hi_req;
    assign hi_req = |(req & prio);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($countones(gnt) == 1));

    p_to_requester_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ((gnt & ~$past(req)) == '0));

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !gnt_valid);

    p_hi_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !($past(hi_req) && ((gnt & ~prio) != '0)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && !done) |=> (gnt == $past(gnt)));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && done) |=> ((gnt == '0) && !gnt_valid));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0) && (req == '0)) |=> !gnt_valid);
endmodule

bind dma_bw_arbiter dma_arb_checker #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .prio      (prio),
    .done      (done),
    .gnt       (gnt),
    .gnt_valid (gnt_valid)
);

// File: tb/sim_dma_bw_arbiter.sv
`timescale 1ns/1ps
module sim_dma_bw_arbiter;
    localparam int N = 6;
    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [N-1:0]   prio = '0;
    logic [N*W-1:0] weight = '0;
    logic           done = 1'b0;
    logic [N-1:0]   gnt;
    logic           gnt_valid;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [N-1:0] exp_q[$];
    int m_cred[N];
    int m_ptr[2];

    always #2 clk = ~clk;

    dma_bw_arbiter #(.N_CH(N), .WGT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .weight(weight),
        .done(done), .gnt(gnt), .gnt_valid(gnt_valid)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int weff(int i);
        int w;
        w = int'(weight[i*W +: W]);
        return (w == 0) ? 1 : w;
    endfunction

    // reference model: predicts one grant from the current inputs
    task automatic model_pick(output int who);
        int  lvl;
        bit  any_in;
        bit  any_cr;
        who = -1;
        lvl = ((req & prio) != '0) ? 1 : 0;
        any_in = 0;
        any_cr = 0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && int'(prio[i]) == lvl) begin
                any_in = 1;
                if (m_cred[i] > 0) any_cr = 1;
            end
        end
        if (!any_in) return;
        if (!any_cr) begin
            for (int i = 0; i < N; i++) begin
                if (int'(prio[i]) == lvl) m_cred[i] = weff(i);
            end
        end
        for (int k = 0; k < N; k++) begin
            int p;
            p = (m_ptr[lvl] + k) % N;
            if (who < 0 && req[p] && int'(prio[p]) == lvl && m_cred[p] > 0) who = p;
        end
        m_cred[who]--;
        m_ptr[lvl] = (who + 1) % N;
    endtask

    // monitor: compares each new grant against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && gnt_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected grant", 32'(gnt), 0);
            end else begin
                logic [N-1:0] e;
                e = exp_q.pop_front();
                chk(gnt == e, "R6/R8/R9 grant order", 32'(gnt), 32'(e));
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        req   = '0;
        done  = 1'b0;
        repeat (3) @(negedge clk);
        chk(gnt == '0 && !gnt_valid, "R1 reset state", 32'(gnt), 0);
        for (int i = 0; i < N; i++) m_cred[i] = 0;
        m_ptr[0] = 0;
        m_ptr[1] = 0;
        exp_q.delete();
        rst_n = 1'b1;
    endtask

    task automatic set_w(int i, int v);
        weight[i*W +: W] = W'(v);
    endtask

    // driver: called at a negedge with the design idle and inputs set
    task automatic grant_step(bit drop, output logic [N-1:0] seen);
        int who;
        int lat;
        model_pick(who);
        if (who >= 0) exp_q.push_back(N'(1) << who);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!gnt_valid && lat < 20);
        chk(lat == 1, "R2 grant latency", 32'(lat), 1);
        seen = gnt;
        if (drop) req = '0;
        repeat (3) begin
            @(negedge clk);
            chk(gnt == seen && !gnt_valid, "R4 grant held", 32'(gnt), 32'(seen));
        end
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk(gnt == '0, "R5 release on done", 32'(gnt), 0);
    endtask

    initial begin
        logic [N-1:0] g;
        int cnt;

        @(negedge clk);
        chk(gnt == '0 && !gnt_valid, "R1 in reset", 32'(gnt), 0);
        for (int i = 0; i < N; i++) set_w(i, 1);
        do_reset();
        chk(gnt == '0 && !gnt_valid, "R1 after release", 32'(gnt), 0);

        // R6, R9: weights 3 and 1 in the low class
        set_w(0, 3); set_w(1, 1);
        req = 6'b000011;
        cnt = 0;
        for (int n = 0; n < 8; n++) begin
            grant_step(0, g);
            if (n < 4 && g[0]) cnt++;
        end
        chk(cnt == 3, "R6 weight 3 share in window", 32'(cnt), 3);

        // R8: equal weights rotate through all channels
        do_reset();
        for (int i = 0; i < N; i++) set_w(i, 1);
        req = '1;
        g = '0;
        begin
            logic [N-1:0] acc;
            acc = '0;
            for (int n = 0; n < N; n++) begin
                grant_step(0, g);
                acc |= g;
            end
            chk(acc == '1, "R8 every channel once per round", 32'(acc), 32'({N{1'b1}}));
        end

        // R3: high class shuts out the low class; then low resumes
        do_reset();
        set_w(3, 2); set_w(5, 1); set_w(0, 2); set_w(1, 1);
        prio = 6'b101000;
        req  = 6'b101011;
        for (int n = 0; n < 5; n++) begin
            grant_step(0, g);
            chk((g & ~prio) == '0, "R3 high class wins", 32'(g), 32'(g & prio));
        end
        req = 6'b000011;
        for (int n = 0; n < 3; n++) grant_step(0, g);
        req = 6'b001011;
        grant_step(0, g);
        chk(g == 6'b001000, "R3 high preempts at next pick", 32'(g), 32'h8);
        req = 6'b000011;
        for (int n = 0; n < 3; n++) grant_step(0, g);
        prio = '0;

        // R7: zero weight behaves as one
        do_reset();
        set_w(2, 0); set_w(4, 2);
        req = 6'b010100;
        cnt = 0;
        for (int n = 0; n < 6; n++) begin
            grant_step(0, g);
            if (g[2]) cnt++;
        end
        chk(cnt == 2, "R7 zero weight counts as one", 32'(cnt), 2);

        // R10: nothing requested, nothing granted
        req = '0;
        repeat (5) begin
            @(negedge clk);
            chk(!gnt_valid && gnt == '0, "R10 idle without requests", 32'(gnt), 0);
        end

        // R4: done while idle has no effect
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk(gnt == '0 && !gnt_valid, "R4 idle done ignored", 32'(gnt), 0);
        req = 6'b000010;
        set_w(1, 5);
        grant_step(1, g);
        chk(g == 6'b000010, "R4 grant after idle done", 32'(g), 32'h2);

        // R4: request dropped while owning, grant still held
        req = 6'b100000;
        grant_step(1, g);
        chk(g == 6'b100000, "R4 held after req drop", 32'(g), 32'h20);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all predicted grants seen", 32'(exp_q.size()), 0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule